// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block keeps wall-clock time and calendar date as a chain of packed-BCD counters. The fields are seconds, minutes, hours, day of week, date, month, year and century. A single-cycle `tick` strobe, one pulse per second produced elsewhere, advances the seconds. Carries pass from field to field within the same clock edge. Hours run in 24-hour form. The date wraps at the real length of each month, and February gets its leap day whenever the two-digit year is a multiple of four. When the year passes 99, the century byte advances.

A `load` strobe writes every field in one cycle from a set of parallel inputs and wins over a tick arriving in the same cycle. Every field is available at all times on parallel outputs. Reading the outputs never stalls the count. The block runs on one system clock with a synchronous active-high reset.

Top module: `bcd_calendar_clock`

## Requirements
- R1: After reset the outputs read seconds 0x00, minutes 0x00, hours 0x00, day of week 0x01, date 0x01, month 0x01, year 0x00 and century RESET_CENTURY (default 0x20).
- R2: When `load` is high at a clock edge, every field takes its `set_*` value at that edge, even if `tick` is high in the same cycle.
- R3: With `load` and `tick` both low, every field keeps its value.
- R4: Each tick with `load` low adds one to the seconds in BCD. Seconds and minutes count 0x00 to 0x59. A seconds wrap to 0x00 advances the minutes at the same edge, and a minutes wrap advances the hours.
- R5: Hours count 0x00 to 0x23. At 23:59:59 a tick gives 00:00:00 and advances both the date and the day of week, all at the same single edge.
- R6: Day of week counts 0x01 to 0x07, and after 0x07 it wraps to 0x01.
- R7: The last date is 0x31 for months 0x01, 0x03, 0x05, 0x07, 0x08, 0x10 and 0x12, and 0x30 for months 0x04, 0x06, 0x09 and 0x11. A day end on the last date sets the date to 0x01 and advances the month.
- R8: In month 0x02 the last date is 0x29 when the BCD year is a multiple of four (this includes 0x00), and 0x28 otherwise.
- R9: A day end on month 0x12, date 0x31 sets the month and the date to 0x01 and adds one to the year in BCD (for example, 0x09 becomes 0x10).
- R10: A year wrap from 0x99 to 0x00 adds one to the century in BCD, and the century wraps from 0x99 to 0x00.
- R11: A field loaded at or beyond its upper limit goes to its lower limit on its next increment, and it still passes a carry to the next field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle strobe that advances the seconds |
| load | input | 1 | Writes all `set_*` values at this edge |
| set_century | input | 8 | BCD century to load |
| set_year | input | 8 | BCD year to load |
| set_month | input | 8 | BCD month to load |
| set_date | input | 8 | BCD date to load |
| set_dow | input | 8 | BCD day of week to load |
| set_hours | input | 8 | BCD hours to load |
| set_minutes | input | 8 | BCD minutes to load |
| set_seconds | input | 8 | BCD seconds to load |
| century | output | 8 | Current century |
| year | output | 8 | Current year |
| month | output | 8 | Current month |
| date | output | 8 | Current date |
| dow | output | 8 | Current day of week |
| hours | output | 8 | Current hours |
| minutes | output | 8 | Current minutes |
| seconds | output | 8 | Current seconds |

## Verification
A broken carry link or a wrong limit stays hidden until a tick reaches that boundary. When it does, a neighbouring field advances too early, too late or not at all, and this is visible on the outputs one clock after that tick. The bench therefore loads a time just before each boundary: minute, midnight, weekday, every month length, the leap and common Februaries, year end and century end. It then issues one tick and compares all eight fields on the next clock. A wrong leap rule is the hardest fault to see, because it only shows on February 28 or 29 of particular years, so several years are tried.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;

    localparam int FIELD_W    = 8;
    localparam int NUM_FIELDS = 8;

    // field indices, least significant first; carry order follows these
    localparam int F_SEC   = 0;
    localparam int F_MIN   = 1;
    localparam int F_HOUR  = 2;
    localparam int F_DOW   = 3;
    localparam int F_DATE  = 4;
    localparam int F_MONTH = 5;
    localparam int F_YEAR  = 6;
    localparam int F_CENT  = 7;

    typedef logic [FIELD_W-1:0] bcd_t;
    typedef logic [NUM_FIELDS-1:0][FIELD_W-1:0] field_vec_t;

    // packed so that field index i lands in byte i
    typedef struct packed {
        bcd_t century;
        bcd_t year;
        bcd_t month;
        bcd_t date;
        bcd_t dow;
        bcd_t hours;
        bcd_t minutes;
        bcd_t seconds;
    } cal_time_t;

    function automatic bcd_t bcd_next(input bcd_t v);
        bcd_t r;
        if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
        else                r = {v[7:4], v[3:0] + 4'd1};
        return r;
    endfunction

    // divisible by four, decided straight from the two digits
    function automatic logic year_is_leap(input bcd_t y);
        logic r;
        if (y[4]) r = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
        else      r = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
        return r;
    endfunction

    function automatic int field_parent(input int idx);
        int p;
        case (idx)
            F_DOW:   p = F_HOUR;
            F_DATE:  p = F_HOUR;
            default: p = idx - 1;
        endcase
        return p;
    endfunction

    function automatic bcd_t field_lo(input int idx);
        bcd_t r;
        case (idx)
            F_DOW, F_DATE, F_MONTH: r = 8'h01;
            default:                r = 8'h00;
        endcase
        return r;
    endfunction

    function automatic bcd_t field_hi(input int idx);
        bcd_t r;
        case (idx)
            F_SEC, F_MIN: r = 8'h59;
            F_HOUR:       r = 8'h23;
            F_DOW:        r = 8'h07;
            F_DATE:       r = 8'h31;
            F_MONTH:      r = 8'h12;
            default:      r = 8'h99;
        endcase
        return r;
    endfunction

    function automatic bcd_t field_reset(input int idx, input bcd_t cent);
        bcd_t r;
        if (idx == F_CENT) r = cent;
        else               r = field_lo(idx);
        return r;
    endfunction

endpackage

// File: rtl/bcd_field_ctr.sv
module bcd_field_ctr
    import bcd_cal_pkg::*;
#(
    parameter bcd_t RST_VAL = 8'h00
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  bcd_t load_val,
    input  logic inc,
    input  bcd_t lo_lim,
    input  bcd_t hi_lim,
    output bcd_t value,
    output logic carry
);

    bcd_t value_nx;

    // at-or-above the limit wraps, so an out-of-range load recovers
    assign carry = inc && !load && (value >= hi_lim);

    always_comb begin
        if (load)       value_nx = load_val;
        else if (carry) value_nx = lo_lim;
        else if (inc)   value_nx = bcd_next(value);
        else            value_nx = value;
    end

    always_ff @(posedge clk) begin
        if (rst) value <= RST_VAL;
        else     value <= value_nx;
    end

    assert_field_load_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> (value == $past(load_val)));

    assert_field_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!load && !inc) |=> $stable(value));

    assert_field_wrap_R11: assert property (@(posedge clk) disable iff (rst)
        carry |=> (value == $past(lo_lim)));

endmodule

// File: rtl/cal_month_len.sv
module cal_month_len
    import bcd_cal_pkg::*;
(
    input  bcd_t year,
    input  bcd_t month,
    output bcd_t last_date,
    output logic leap
);

    assign leap = year_is_leap(year);

    always_comb begin
        case (month)
            8'h02:                      last_date = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_date = 8'h30;
            default:                    last_date = 8'h31;
        endcase
    end

endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock
    import bcd_cal_pkg::*;
#(
    parameter logic [7:0] RESET_CENTURY = 8'h20
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       load,
    input  logic [7:0] set_century,
    input  logic [7:0] set_year,
    input  logic [7:0] set_month,
    input  logic [7:0] set_date,
    input  logic [7:0] set_dow,
    input  logic [7:0] set_hours,
    input  logic [7:0] set_minutes,
    input  logic [7:0] set_seconds,
    output logic [7:0] century,
    output logic [7:0] year,
    output logic [7:0] month,
    output logic [7:0] date,
    output logic [7:0] dow,
    output logic [7:0] hours,
    output logic [7:0] minutes,
    output logic [7:0] seconds
);

    cal_time_t             set_time;
    cal_time_t             cur_time;
    field_vec_t            set_vec;
    field_vec_t            cur_vec;
    field_vec_t            lo_vec;
    field_vec_t            hi_vec;
    logic [NUM_FIELDS-1:0] inc_vec;
    logic [NUM_FIELDS-1:0] carry_vec;
    bcd_t                  month_last;
    logic                  leap_year;

    assign set_time = '{century: set_century, year: set_year, month: set_month,
                        date: set_date, dow: set_dow, hours: set_hours,
                        minutes: set_minutes, seconds: set_seconds};
    assign set_vec  = set_time;
    assign cur_time = cur_vec;

    cal_month_len u_len (
        .year      (cur_vec[F_YEAR]),
        .month     (cur_vec[F_MONTH]),
        .last_date (month_last),
        .leap      (leap_year)
    );

    genvar gi;
    generate
        for (gi = 0; gi < NUM_FIELDS; gi++) begin : g_field
            if (gi == F_SEC) begin : g_src
                assign inc_vec[gi] = tick;
            end else begin : g_src
                assign inc_vec[gi] = carry_vec[field_parent(gi)];
            end

            if (gi == F_DATE) begin : g_lim
                assign hi_vec[gi] = month_last;
            end else begin : g_lim
                assign hi_vec[gi] = field_hi(gi);
            end
            assign lo_vec[gi] = field_lo(gi);

            bcd_field_ctr #(
                .RST_VAL (field_reset(gi, RESET_CENTURY))
            ) u_ctr (
                .clk      (clk),
                .rst      (rst),
                .load     (load),
                .load_val (set_vec[gi]),
                .inc      (inc_vec[gi]),
                .lo_lim   (lo_vec[gi]),
                .hi_lim   (hi_vec[gi]),
                .value    (cur_vec[gi]),
                .carry    (carry_vec[gi])
            );
        end
    endgenerate

    assign century = cur_time.century;
    assign year    = cur_time.year;
    assign month   = cur_time.month;
    assign date    = cur_time.date;
    assign dow     = cur_time.dow;
    assign hours   = cur_time.hours;
    assign minutes = cur_time.minutes;
    assign seconds = cur_time.seconds;

    // a tick that ends a normal day
    logic day_end;
    assign day_end = tick && !load && (hours == 8'h23) && (minutes == 8'h59)
                     && (seconds == 8'h59);

    assert_min_roll_R4: assert property (@(posedge clk) disable iff (rst)
        (tick && !load && seconds == 8'h59) |=>
            (seconds == 8'h00) && (minutes != $past(minutes)));

    assert_midnight_R5: assert property (@(posedge clk) disable iff (rst)
        day_end |=> (hours == 8'h00) && (minutes == 8'h00) && (seconds == 8'h00)
                    && (date != $past(date)) && (dow != $past(dow)));

    assert_dow_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        (day_end && dow == 8'h07) |=> (dow == 8'h01));

    assert_leap_day_R8: assert property (@(posedge clk) disable iff (rst)
        (day_end && month == 8'h02 && date == 8'h28 && leap_year) |=>
            (date == 8'h29) && (month == 8'h02));

    assert_year_end_R9: assert property (@(posedge clk) disable iff (rst)
        (day_end && month == 8'h12 && date == 8'h31) |=>
            (month == 8'h01) && (date == 8'h01) && (year != $past(year)));

    assert_cent_step_R10: assert property (@(posedge clk) disable iff (rst)
        (day_end && month == 8'h12 && date == 8'h31 && year == 8'h99) |=>
            (year == 8'h00) && (century != $past(century)));

    assert_cent_wrap_R10: assert property (@(posedge clk) disable iff (rst)
        carry_vec[F_CENT] |=> (century == 8'h00));

endmodule

// File: tb/sim_bcd_calendar_clock.sv
module sim_bcd_calendar_clock;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       load = 1'b0;
    logic [63:0] set_all = '0;
    logic [7:0] century, year, month, date, dow, hours, minutes, seconds;
    logic [63:0] now_all;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    bcd_calendar_clock u0 (
        .clk (clk), .rst (rst), .tick (tick), .load (load),
        .set_century (set_all[63:56]), .set_year (set_all[55:48]),
        .set_month   (set_all[47:40]), .set_date (set_all[39:32]),
        .set_dow     (set_all[31:24]), .set_hours (set_all[23:16]),
        .set_minutes (set_all[15:8]),  .set_seconds (set_all[7:0]),
        .century (century), .year (year), .month (month), .date (date),
        .dow (dow), .hours (hours), .minutes (minutes), .seconds (seconds)
    );

    // layout: century year month date dow hours minutes seconds
    assign now_all = {century, year, month, date, dow, hours, minutes, seconds};

    task automatic check_now(input string tag, input logic [63:0] exp);
        checks++;
        if (now_all !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, now_all, exp);
        end
    endtask

    task automatic load_time(input logic [63:0] t);
        @(negedge clk);
        set_all = t;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic one_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic roll_case(input string tag, input logic [63:0] start,
                             input logic [63:0] exp);
        load_time(start);
        one_tick();
        check_now(tag, exp);
    endtask

    task automatic test_reset();
        check_now("R1 reset", 64'h20_00_01_01_01_00_00_00);
    endtask

    task automatic test_load_priority();
        @(negedge clk);
        set_all = 64'h19_87_06_14_05_08_41_17;
        load = 1'b1;
        tick = 1'b1;
        @(negedge clk);
        load = 1'b0;
        tick = 1'b0;
        check_now("R2 load beats tick", 64'h19_87_06_14_05_08_41_17);
    endtask

    task automatic test_hold();
        load_time(64'h20_31_07_04_02_10_20_30);
        set_all = 64'h11_11_11_11_11_11_11_11;
        repeat (6) @(negedge clk);
        check_now("R3 idle hold", 64'h20_31_07_04_02_10_20_30);
    endtask

    task automatic test_seconds_minutes();
        load_time(64'h20_24_03_10_02_12_34_58);
        one_tick();
        check_now("R4 seconds step", 64'h20_24_03_10_02_12_34_59);
        one_tick();
        check_now("R4 minute carry", 64'h20_24_03_10_02_12_35_00);
        roll_case("R4 hour carry", 64'h20_24_03_10_02_12_59_59,
                  64'h20_24_03_10_02_13_00_00);
        roll_case("R4 digit carry", 64'h20_24_03_10_02_12_09_09,
                  64'h20_24_03_10_02_12_09_10);
    endtask

    task automatic test_midnight();
        roll_case("R5 midnight", 64'h20_24_05_15_03_23_59_59,
                  64'h20_24_05_16_04_00_00_00);
    endtask

    task automatic test_dow();
        roll_case("R6 weekday wrap", 64'h20_24_05_15_07_23_59_59,
                  64'h20_24_05_16_01_00_00_00);
    endtask

    task automatic test_month_len();
        roll_case("R7 jan 30", 64'h20_23_01_30_01_23_59_59, 64'h20_23_01_31_02_00_00_00);
        roll_case("R7 jan 31", 64'h20_23_01_31_01_23_59_59, 64'h20_23_02_01_02_00_00_00);
        roll_case("R7 apr 30", 64'h20_23_04_30_01_23_59_59, 64'h20_23_05_01_02_00_00_00);
        roll_case("R7 aug 31", 64'h20_23_08_31_01_23_59_59, 64'h20_23_09_01_02_00_00_00);
        roll_case("R7 sep 30", 64'h20_23_09_30_01_23_59_59, 64'h20_23_10_01_02_00_00_00);
        roll_case("R7 nov 30", 64'h20_23_11_30_01_23_59_59, 64'h20_23_12_01_02_00_00_00);
    endtask

    task automatic test_leap();
        roll_case("R8 feb 28 y23", 64'h20_23_02_28_01_23_59_59, 64'h20_23_03_01_02_00_00_00);
        roll_case("R8 feb 28 y24", 64'h20_24_02_28_01_23_59_59, 64'h20_24_02_29_02_00_00_00);
        roll_case("R8 feb 29 y24", 64'h20_24_02_29_01_23_59_59, 64'h20_24_03_01_02_00_00_00);
        roll_case("R8 feb 28 y00", 64'h20_00_02_28_01_23_59_59, 64'h20_00_02_29_02_00_00_00);
        roll_case("R8 feb 28 y12", 64'h20_12_02_28_01_23_59_59, 64'h20_12_02_29_02_00_00_00);
        roll_case("R8 feb 28 y10", 64'h20_10_02_28_01_23_59_59, 64'h20_10_03_01_02_00_00_00);
        roll_case("R8 feb 28 y96", 64'h20_96_02_28_01_23_59_59, 64'h20_96_02_29_02_00_00_00);
        roll_case("R8 feb 28 y98", 64'h20_98_02_28_01_23_59_59, 64'h20_98_03_01_02_00_00_00);
    endtask

    task automatic test_year_end();
        roll_case("R9 year end", 64'h20_09_12_31_06_23_59_59, 64'h20_10_01_01_07_00_00_00);
    endtask

    task automatic test_century();
        roll_case("R10 century step", 64'h20_99_12_31_04_23_59_59,
                  64'h21_00_01_01_05_00_00_00);
        roll_case("R10 century wrap", 64'h99_99_12_31_04_23_59_59,
                  64'h00_00_01_01_05_00_00_00);
    endtask

    task automatic test_out_of_range();
        roll_case("R11 seconds over limit", 64'h20_24_03_10_02_12_34_75,
                  64'h20_24_03_10_02_12_35_00);
        roll_case("R11 date over limit", 64'h20_23_04_31_01_23_59_59,
                  64'h20_23_05_01_02_00_00_00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_load_priority();
        test_hold();
        test_seconds_minutes();
        test_midnight();
        test_dow();
        test_month_len();
        test_leap();
        test_year_end();
        test_century();
        test_out_of_range();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired actual running expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule